// File: doc/BRIEF.md
# I2C Byte-Memory Target

This block is a target (slave) on a two-wire I2C bus. It holds a small byte memory behind an internal pointer. The block samples the clock and data lines through synchronisers. It pulls the data line low through an open-drain enable when it acknowledges and when it sends a zero bit. A bus controller sets the pointer with the first byte of a write transaction. The bytes that follow in that write are stored at successive locations.

A read transaction, usually opened with a repeated START after the pointer byte, returns the byte at the pointer. It returns one more byte after each acknowledge from the controller, and the pointer advances each time. A pointer value outside the memory is refused. The block takes no part in a transaction that carries another device address. Clock stretching and general-call handling are not provided.

Top module: `i2cm_target`

## Requirements
- R1: After reset, `sda_oe` is low and the pointer is zero; the memory contents are kept through reset.
- R2: The first byte after a START carries the device address in its upper seven bits (default 0010000) and the direction in bit 0 (0 = write, 1 = read), sent MSB first. When the address matches, the target holds SDA low during the ninth clock.
- R3: When the address does not match, the target gives no ACK. Until the next START it neither acknowledges nor stores any byte.
- R4: In a write, the first byte after the address is the pointer. A value from 0 to MEM_DEPTH-1 (default depth 8) is acknowledged and loaded.
- R5: A pointer byte of MEM_DEPTH or more, such as 0x10, is answered with a NACK.
- R6: Each further byte of the write is stored at the pointer and acknowledged, and the pointer then increments by one.
- R7: A read returns the byte at the pointer, MSB first. After each ACK from the controller it returns the next location, and the pointer increments once per byte sent.
- R8: After a NACK from the controller on a read byte, the target releases SDA and keeps it released.
- R9: `sda_oe` changes only while SCL is low.
- R10: A START seen at any point, even in the middle of a byte, restarts address reception. A STOP returns the target to idle. Both leave SDA released.
- R11: Incoming bits are taken on the rising edge of SCL, MSB first.
- R12: A data byte that arrives when the pointer has passed the last location gets a NACK and is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | When high, the target pulls the data line low |

## Verification
The SCL fall that closes a received data byte does three things in one clock. It issues the memory write, it advances the pointer and it decides the ACK, and all three depend on the same pointer value. The bench provokes the boundary by writing at location 6. The byte at location 7 must still be acknowledged and stored. The byte after it must get a NACK and leave the memory untouched. A readback from location 6 then judges the two stored bytes, and a checker property ties each write strobe to a pointer that is exactly one past the written location.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WR,
    ST_ACK,
    ST_TX,
    ST_RACK
  } tgt_state_e;

endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  // data edges with the clock line high on both samples
  assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2cm_byte_mem.sv
module i2cm_byte_mem #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [DEPTH];

  // single write port, registered read port: RAM-inferable
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

endmodule

// File: rtl/i2cm_target.sv
module i2cm_target
  import i2cm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0010000,
  parameter int         MEM_DEPTH   = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int         IDX_W   = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
  localparam logic [8:0] DEPTH_L = 9'(MEM_DEPTH);
  localparam logic [3:0] LAST_BIT = 4'd8;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_i),
    .sda_in   (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  tgt_state_e        state_q, ack_next_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] rx_sh_q, tx_sh_q, ptr_q;
  logic              oe_q, mack_q;
  logic              mem_we_q;
  logic [IDX_W-1:0]  mem_wa_q;
  logic [BYTE_W-1:0] mem_wd_q;
  logic [BYTE_W-1:0] rd_data, tx_load;
  logic              in_range, rx_in_range, addr_hit, is_idle;

  i2cm_byte_mem #(.DEPTH(MEM_DEPTH), .DW(BYTE_W), .AW(IDX_W)) u_mem (
    .clk  (clk),
    .we   (mem_we_q),
    .waddr(mem_wa_q),
    .wdata(mem_wd_q),
    .raddr(ptr_q[IDX_W-1:0]),
    .rdata(rd_data)
  );

  assign in_range    = ({1'b0, ptr_q} < DEPTH_L);
  assign rx_in_range = ({1'b0, rx_sh_q} < DEPTH_L);
  assign addr_hit    = (rx_sh_q[7:1] == DEV_ADDR);
  assign tx_load     = in_range ? rd_data : '1;
  assign is_idle     = (state_q == ST_IDLE);
  assign sda_oe      = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ack_next_q <= ST_IDLE;
      bit_cnt_q  <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      ptr_q      <= '0;
      oe_q       <= 1'b0;
      mack_q     <= 1'b0;
      mem_we_q   <= 1'b0;
      mem_wa_q   <= '0;
      mem_wd_q   <= '0;
    end else begin
      mem_we_q <= 1'b0;
      if (start_evt) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (stop_evt) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (scl_rise && bit_cnt_q < LAST_BIT) begin
              rx_sh_q   <= {rx_sh_q[6:0], sda_lvl};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
              bit_cnt_q <= '0;
              state_q   <= ST_IDLE;
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  oe_q       <= 1'b1;
                  state_q    <= ST_ACK;
                  ack_next_q <= rx_sh_q[0] ? ST_TX : ST_PTR;
                end
              end else if (state_q == ST_PTR) begin
                if (rx_in_range) begin
                  ptr_q      <= rx_sh_q;
                  oe_q       <= 1'b1;
                  state_q    <= ST_ACK;
                  ack_next_q <= ST_WR;
                end
              end else if (in_range) begin
                mem_we_q   <= 1'b1;
                mem_wa_q   <= ptr_q[IDX_W-1:0];
                mem_wd_q   <= rx_sh_q;
                ptr_q      <= ptr_q + 8'd1;
                oe_q       <= 1'b1;
                state_q    <= ST_ACK;
                ack_next_q <= ST_WR;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt_q <= '0;
              state_q   <= ack_next_q;
              if (ack_next_q == ST_TX) begin
                tx_sh_q <= tx_load;
                oe_q    <= ~tx_load[7];
                if (in_range) ptr_q <= ptr_q + 8'd1;
              end else begin
                oe_q <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt_q == LAST_BIT) begin
                oe_q      <= 1'b0;
                bit_cnt_q <= '0;
                state_q   <= ST_RACK;
              end else begin
                tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                oe_q    <= ~tx_sh_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_sh_q <= tx_load;
                oe_q    <= ~tx_load[7];
                if (in_range) ptr_q <= ptr_q + 8'd1;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cm_target_chk.sv
module i2cm_target_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_i,
  input logic             sda_oe,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             is_idle,
  input logic             mem_we,
  input logic [IDX_W-1:0] mem_wa,
  input logic [7:0]       ptr
);

  // R1
  reset_release_chk: assert property (@(posedge clk) rst |=> !sda_oe);

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> (!scl_i && !$past(scl_i)));

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !sda_oe);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    is_idle |-> !sda_oe);

  // R6
  wr_ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ptr == 8'(mem_wa) + 8'd1));

endmodule

bind i2cm_target i2cm_target_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .is_idle  (is_idle),
  .mem_we   (mem_we_q),
  .mem_wa   (mem_wa_q),
  .ptr      (ptr_q)
);

// File: tb/i2cm_target_tb.sv
module i2cm_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'b0010000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_line;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  assign sda_line = ~(m_low | sda_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cm_target #(.DEV_ADDR(DEV)) u_dut (
    .clk   (clk),
    .rst   (rst),
    .scl_i (m_scl),
    .sda_i (sda_line),
    .sda_oe(sda_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(); m_scl = 1'b1; wq();
    m_low = 1'b1; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    m_scl = 1'b0; m_low = 1'b0; wq();
    m_scl = 1'b1; wq(); m_low = 1'b1; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(); m_scl = 1'b1; wq(); m_low = 1'b0; wq();
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; wq(); m_scl = 1'b1; wq(); b = sda_line; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic t_reset();
    rst = 1'b1; wq(2); rst = 1'b0; wq();
    chk("R1 oe after reset", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic t_write_seq();
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R2 address ack", {7'd0, a}, 8'd1);
    send_byte(8'h02, a);       chk("R4 pointer ack", {7'd0, a}, 8'd1);
    send_byte(8'hA5, a);       chk("R6 data ack 1", {7'd0, a}, 8'd1);
    send_byte(8'h5A, a);       chk("R6 data ack 2", {7'd0, a}, 8'd1);
    bus_stop();
  endtask

  task automatic t_read_back();
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h02, a);
    bus_rstart();
    send_byte({DEV, 1'b1}, a); chk("R7 read address ack", {7'd0, a}, 8'd1);
    recv_byte(1'b1, v);        chk("R7 R11 first byte", v, 8'hA5);
    recv_byte(1'b0, v);        chk("R7 R6 next byte", v, 8'h5A);
    wq();
    chk("R8 released after nack", {7'd0, sda_oe}, 8'd0);
    bus_stop();
  endtask

  task automatic t_bad_ptr();
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h10, a); chk("R5 out-of-range nack", {7'd0, a}, 8'd0);
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a); chk("R3 no ack on mismatch", {7'd0, a}, 8'd0);
    send_byte(8'h03, a);               chk("R3 ignored byte", {7'd0, a}, 8'd0);
    send_byte(8'hEE, a);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h03, a);
    bus_rstart();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, v); chk("R3 memory untouched", v, 8'h5A);
    bus_stop();
  endtask

  task automatic t_edge();
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h06, a);
    send_byte(8'h11, a); chk("R6 ack at 6", {7'd0, a}, 8'd1);
    send_byte(8'h22, a); chk("R6 ack at last", {7'd0, a}, 8'd1);
    send_byte(8'h33, a); chk("R12 nack past end", {7'd0, a}, 8'd0);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h06, a);
    bus_rstart();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b1, v); chk("R12 loc 6", v, 8'h11);
    recv_byte(1'b0, v); chk("R12 loc 7", v, 8'h22);
    bus_stop();
  endtask

  task automatic t_restart_mid();
    logic a;
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_rstart();
    send_byte({DEV, 1'b0}, a); chk("R10 address after mid-byte start", {7'd0, a}, 8'd1);
    send_byte(8'h00, a);       chk("R10 pointer ack", {7'd0, a}, 8'd1);
    send_byte(8'hC3, a);
    bus_stop();
  endtask

  task automatic t_ptr_reset();
    logic a;
    logic [7:0] v;
    t_reset();
    bus_start();
    send_byte({DEV, 1'b1}, a); chk("R1 read ack after reset", {7'd0, a}, 8'd1);
    recv_byte(1'b0, v);        chk("R1 pointer zero memory kept", v, 8'hC3);
    bus_stop();
  endtask

  initial begin
    wq(2);
    t_reset();
    t_write_seq();
    t_read_back();
    t_bad_ptr();
    t_wrong_addr();
    t_edge();
    t_restart_mid();
    t_ptr_reset();
    wq(2);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule